// File: doc/BRIEF.md
# Ethernet Transceiver Control Register

This block holds the 16-bit basic control word of a 10/100 Ethernet transceiver. A management agent writes and reads it through single-cycle strobes. The block turns the stored word into the control levels and pulses that the rest of the transceiver uses: forced speed and duplex, loopback, powerdown, output isolation, autonegotiation enable and restart, and a software reset pulse.

The manual speed setting is qualified by a 100 Mb/s strap pin. The manual duplex setting is merged with a full-duplex strap pin. Both apply only while autonegotiation is off. The block also owns the collision output of the media-independent interface. In collision-test mode that output mirrors transmit enable. Otherwise it passes the collision indication from the transceiver core.

The register has two self-clearing bits. A software reset loads the default word 0x1000 on the edge that takes the write, and raises a one-cycle pulse. A restart request stays pending until the autonegotiation logic acknowledges it. When it is written, it also pulses a clear of the autonegotiation-done status.

Top module: `phy_ctrl_reg`

## Requirements
- R1: A synchronous reset loads the word 0x1000. In that state `an_enable` is 1, `mii_oe` is 1, and every other control output and pulse is 0.
- R2: A read (`rd_en` high for one cycle) returns the stored word on `rdata` after that edge. Bits 15 and 6:0 read as 0, and writes to bits 6:0 are ignored.
- R3: Writing 1 to bit 15 loads 0x1000 on that edge, whatever else the write carries. `soft_reset_pulse` is high for exactly the following cycle.
- R4: `eff_speed100` equals (NOT bit 12) AND bit 13 AND `speed_strap`. Like every level output, it is registered one cycle after the stored word and the strap.
- R5: `eff_full_dup` equals (NOT bit 12) AND (bit 8 OR `fdx_strap`).
- R6: `loopback` follows bit 14 and `powerdown` follows bit 11. Writes and reads keep working while powerdown is set.
- R7: `mii_oe` is the inverse of bit 10 (isolate).
- R8: Writing 1 to bit 9 sets `an_restart` on that edge and pulses `an_done_clr` for one cycle. `an_restart` stays set until the edge that samples `an_restart_ack` high. Writing 0 to bit 9 does not cancel a pending restart.
- R9: With bit 7 set, `col_out` gives `tx_en` one cycle late. With bit 7 clear, it gives `col_in` one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| speed_strap | input | 1 | 100 Mb/s strap; ANDed with the speed bit |
| fdx_strap | input | 1 | Full-duplex strap; ORed with the duplex bit |
| an_restart_ack | input | 1 | Autonegotiation logic has started the restart |
| tx_en | input | 1 | MII transmit enable |
| col_in | input | 1 | Collision indication from the transceiver core |
| col_out | output | 1 | MII collision output |
| soft_reset_pulse | output | 1 | One-cycle software reset to the transceiver |
| an_done_clr | output | 1 | One-cycle clear of autonegotiation-done status |
| an_restart | output | 1 | Pending autonegotiation restart |
| an_enable | output | 1 | Autonegotiation enabled |
| eff_speed100 | output | 1 | Forced 100 Mb/s operation |
| eff_full_dup | output | 1 | Forced full-duplex operation |
| loopback | output | 1 | Loopback mode |
| powerdown | output | 1 | Powerdown mode |
| mii_oe | output | 1 | MII output enable, low when isolated |

## Verification
The bench targets strap combining. A speed bit that ignores its strap, or a duplex bit that ignores the autonegotiation gate, shows up as a wrong forced output in one of the table rows. Writes carrying reserved bits or a soft reset alongside other bits catch a design that stores bits 6:0, or one that lets the write data win over the default. The restart sequence writes 0 to bit 9 while a restart is pending, then acknowledges it. A design that cancels on write, or that never clears, holds the wrong `an_restart` level. The collision checks swap `tx_en` and `col_in` in opposite directions, so selecting the wrong source flips `col_out`.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned B_SRST   = 15;
  localparam int unsigned B_LOOP   = 14;
  localparam int unsigned B_SPD    = 13;
  localparam int unsigned B_ANEN   = 12;
  localparam int unsigned B_PDN    = 11;
  localparam int unsigned B_ISO    = 10;
  localparam int unsigned B_ANRST  = 9;
  localparam int unsigned B_DUP    = 8;
  localparam int unsigned B_COLT   = 7;
  localparam logic [CTRL_W-1:0] CTRL_DEFAULT = 16'h1000;
  localparam logic [CTRL_W-1:0] CTRL_RW_MASK = 16'h7F80;
endpackage

// File: rtl/phy_ctrl_store.sv
module phy_ctrl_store
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         restart_ack,
  output logic [W-1:0] word_q,
  output logic         srst_pulse_q,
  output logic         done_clr_q
);
  logic         wr_srst;
  logic [W-1:0] word_nxt;
  logic         keep_restart;

  assign wr_srst      = wr_en && wdata[B_SRST];
  assign keep_restart = word_q[B_ANRST] && !restart_ack;

  always_comb begin
    word_nxt = word_q;
    if (wr_srst) begin
      word_nxt = CTRL_DEFAULT;
    end else if (wr_en) begin
      word_nxt = wdata & CTRL_RW_MASK;
      word_nxt[B_ANRST] = wdata[B_ANRST] || keep_restart;
    end else begin
      word_nxt[B_ANRST] = keep_restart;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q       <= CTRL_DEFAULT;
      srst_pulse_q <= 1'b0;
      done_clr_q   <= 1'b0;
    end else begin
      word_q       <= word_nxt;
      srst_pulse_q <= wr_srst;
      done_clr_q   <= wr_en && !wr_srst && wdata[B_ANRST];
    end
  end
endmodule

// File: rtl/phy_ctrl_read.sv
module phy_ctrl_read
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic [W-1:0] word,
  output logic [W-1:0] rdata_q
);
  logic [W-1:0] visible;

  for (genvar i = 0; i < W; i++) begin : g_mask
    if (CTRL_RW_MASK[i]) begin : g_live
      assign visible[i] = word[i];
    end else begin : g_zero
      assign visible[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= visible;
    end
  end
endmodule

// File: rtl/phy_ctrl_drive.sv
module phy_ctrl_drive (
  input  logic clk,
  input  logic rst,
  input  logic loop_bit,
  input  logic spd_bit,
  input  logic anen_bit,
  input  logic pdn_bit,
  input  logic iso_bit,
  input  logic dup_bit,
  input  logic colt_bit,
  input  logic speed_strap,
  input  logic fdx_strap,
  input  logic tx_en,
  input  logic col_in,
  output logic loopback_q,
  output logic speed100_q,
  output logic anen_q,
  output logic pdn_q,
  output logic oe_q,
  output logic fdup_q,
  output logic col_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      loopback_q <= 1'b0;
      speed100_q <= 1'b0;
      anen_q     <= 1'b1;
      pdn_q      <= 1'b0;
      oe_q       <= 1'b1;
      fdup_q     <= 1'b0;
      col_q      <= 1'b0;
    end else begin
      loopback_q <= loop_bit;
      speed100_q <= !anen_bit && spd_bit && speed_strap;
      anen_q     <= anen_bit;
      pdn_q      <= pdn_bit;
      oe_q       <= !iso_bit;
      fdup_q     <= !anen_bit && (dup_bit || fdx_strap);
      col_q      <= colt_bit ? tx_en : col_in;
    end
  end
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         speed_strap,
  input  logic         fdx_strap,
  input  logic         an_restart_ack,
  input  logic         tx_en,
  input  logic         col_in,
  output logic         col_out,
  output logic         soft_reset_pulse,
  output logic         an_done_clr,
  output logic         an_restart,
  output logic         an_enable,
  output logic         eff_speed100,
  output logic         eff_full_dup,
  output logic         loopback,
  output logic         powerdown,
  output logic         mii_oe
);
  logic [W-1:0] word;

  phy_ctrl_store #(.W(W)) u_store (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wdata        (wdata),
    .restart_ack  (an_restart_ack),
    .word_q       (word),
    .srst_pulse_q (soft_reset_pulse),
    .done_clr_q   (an_done_clr)
  );

  phy_ctrl_read #(.W(W)) u_read (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .word    (word),
    .rdata_q (rdata)
  );

  phy_ctrl_drive u_drive (
    .clk         (clk),
    .rst         (rst),
    .loop_bit    (word[B_LOOP]),
    .spd_bit     (word[B_SPD]),
    .anen_bit    (word[B_ANEN]),
    .pdn_bit     (word[B_PDN]),
    .iso_bit     (word[B_ISO]),
    .dup_bit     (word[B_DUP]),
    .colt_bit    (word[B_COLT]),
    .speed_strap (speed_strap),
    .fdx_strap   (fdx_strap),
    .tx_en       (tx_en),
    .col_in      (col_in),
    .loopback_q  (loopback),
    .speed100_q  (eff_speed100),
    .anen_q      (an_enable),
    .pdn_q       (powerdown),
    .oe_q        (mii_oe),
    .fdup_q      (eff_full_dup),
    .col_q       (col_out)
  );

  assign an_restart = word[B_ANRST];
endmodule

// File: rtl/phy_ctrl_reg_chk.sv
module phy_ctrl_reg_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic wr_srst_bit,
  input logic an_restart_ack,
  input logic speed_strap,
  input logic fdx_strap,
  input logic soft_reset_pulse,
  input logic an_done_clr,
  input logic an_restart,
  input logic an_enable,
  input logic eff_speed100,
  input logic eff_full_dup,
  input logic loopback,
  input logic powerdown,
  input logic mii_oe
);
  AST_SRST_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    soft_reset_pulse |-> $past(wr_en && wr_srst_bit)); // R3

  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    soft_reset_pulse |=> ##1 (an_enable && !loopback && !powerdown && mii_oe)); // R3

  AST_SPEED_GATED: assert property (@(posedge clk) disable iff (rst)
    eff_speed100 |-> (!an_enable && $past(speed_strap))); // R4

  AST_DUP_STRAP: assert property (@(posedge clk) disable iff (rst)
    (!an_enable && $past(fdx_strap)) |-> eff_full_dup); // R5

  AST_DONECLR_WITH_RESTART: assert property (@(posedge clk) disable iff (rst)
    an_done_clr |-> an_restart); // R8

  AST_RESTART_HOLD: assert property (@(posedge clk) disable iff (rst)
    (an_restart && !an_restart_ack && !(wr_en && wr_srst_bit)) |=> an_restart); // R8

  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (an_restart && an_restart_ack && !wr_en) |=> !an_restart); // R8
endmodule

bind phy_ctrl_reg phy_ctrl_reg_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .wr_en            (wr_en),
  .wr_srst_bit      (wdata[15]),
  .an_restart_ack   (an_restart_ack),
  .speed_strap      (speed_strap),
  .fdx_strap        (fdx_strap),
  .soft_reset_pulse (soft_reset_pulse),
  .an_done_clr      (an_done_clr),
  .an_restart       (an_restart),
  .an_enable        (an_enable),
  .eff_speed100     (eff_speed100),
  .eff_full_dup     (eff_full_dup),
  .loopback         (loopback),
  .powerdown        (powerdown),
  .mii_oe           (mii_oe)
);

// File: tb/phy_ctrl_reg_tb.sv
module phy_ctrl_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {wdata, speed_strap, fdx_strap, exp_rdata, spd, dup, loop, pdn, oe, anen}
  localparam logic [39:0] VEC [NV] = '{
    {16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h2000, 1'b1, 1'b0, 16'h2000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h2000, 1'b0, 1'b0, 16'h2000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h0100, 1'b0, 1'b0, 16'h0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h3100, 1'b1, 1'b1, 16'h3100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {16'h407F, 1'b0, 1'b0, 16'h4000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {16'h0800, 1'b0, 1'b0, 16'h0800, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'h0400, 1'b0, 1'b0, 16'h0400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h2D00, 1'b1, 1'b0, 16'h2D00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic speed_strap = 1'b0, fdx_strap = 1'b0, an_restart_ack = 1'b0;
  logic tx_en = 1'b0, col_in = 1'b0;
  logic col_out, soft_reset_pulse, an_done_clr, an_restart, an_enable;
  logic eff_speed100, eff_full_dup, loopback, powerdown, mii_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_ctrl_reg u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .speed_strap(speed_strap), .fdx_strap(fdx_strap),
    .an_restart_ack(an_restart_ack), .tx_en(tx_en), .col_in(col_in),
    .col_out(col_out), .soft_reset_pulse(soft_reset_pulse),
    .an_done_clr(an_done_clr), .an_restart(an_restart), .an_enable(an_enable),
    .eff_speed100(eff_speed100), .eff_full_dup(eff_full_dup),
    .loopback(loopback), .powerdown(powerdown), .mii_oe(mii_oe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(output logic [15:0] d);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (CLK_PERIOD * 10000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 an_enable", 16'(an_enable), 16'h1);
    chk("R1 mii_oe", 16'(mii_oe), 16'h1);
    chk("R1 other outputs",
        16'({soft_reset_pulse, an_done_clr, an_restart, eff_speed100,
             eff_full_dup, loopback, powerdown}), 16'h0);
    rd(r);
    chk("R1 reset word", r, 16'h1000);

    // Vector table: R2 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      speed_strap = VEC[i][23];
      fdx_strap   = VEC[i][22];
      wr(VEC[i][39:24]);
      @(negedge clk);
      chk("R4 eff_speed100", 16'(eff_speed100), 16'(VEC[i][5]));
      chk("R5 eff_full_dup", 16'(eff_full_dup), 16'(VEC[i][4]));
      chk("R6 loopback", 16'(loopback), 16'(VEC[i][3]));
      chk("R6 powerdown", 16'(powerdown), 16'(VEC[i][2]));
      chk("R7 mii_oe", 16'(mii_oe), 16'(VEC[i][1]));
      chk("R4 an_enable", 16'(an_enable), 16'(VEC[i][0]));
      rd(r);
      chk("R2 readback", r, VEC[i][21:6]);
    end

    // R3 soft reset overrides other written bits
    speed_strap = 1'b1; fdx_strap = 1'b0;
    wr(16'hA100);
    chk("R3 pulse high", 16'(soft_reset_pulse), 16'h1);
    @(negedge clk);
    chk("R3 pulse one cycle", 16'(soft_reset_pulse), 16'h0);
    rd(r);
    chk("R3 default word", r, 16'h1000);
    chk("R3 an_enable back", 16'(an_enable), 16'h1);
    chk("R3 duplex cleared", 16'(eff_full_dup), 16'h0);

    // R6 management while powered down
    wr(16'h0800);
    wr(16'h0880);
    rd(r);
    chk("R6 write in powerdown", r, 16'h0880);
    chk("R6 powerdown level", 16'(powerdown), 16'h1);

    // R8 restart sequence
    wr(16'h1200);
    chk("R8 done_clr pulse", 16'(an_done_clr), 16'h1);
    chk("R8 restart set", 16'(an_restart), 16'h1);
    @(negedge clk);
    chk("R8 done_clr one cycle", 16'(an_done_clr), 16'h0);
    repeat (4) @(negedge clk);
    chk("R8 restart held", 16'(an_restart), 16'h1);
    wr(16'h1000);
    chk("R8 write 0 keeps restart", 16'(an_restart), 16'h1);
    rd(r);
    chk("R8 restart readback", r, 16'h1200);
    an_restart_ack = 1'b1;
    @(negedge clk);
    an_restart_ack = 1'b0;
    chk("R8 cleared after ack", 16'(an_restart), 16'h0);
    rd(r);
    chk("R8 word after ack", r, 16'h1000);

    // R9 collision test
    wr(16'h0080);
    tx_en = 1'b1; col_in = 1'b0;
    @(negedge clk);
    chk("R9 coltst follows tx_en", 16'(col_out), 16'h1);
    tx_en = 1'b0; col_in = 1'b1;
    @(negedge clk);
    chk("R9 coltst ignores col_in", 16'(col_out), 16'h0);
    wr(16'h0000);
    tx_en = 1'b1; col_in = 1'b0;
    @(negedge clk);
    chk("R9 normal ignores tx_en", 16'(col_out), 16'h0);
    tx_en = 1'b0; col_in = 1'b1;
    @(negedge clk);
    chk("R9 normal follows col_in", 16'(col_out), 16'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule